// File: doc/BRIEF.md
# Two-wire bus start/stop condition watcher

This block sits beside a two-wire serial bus interface and watches the clock and data lines for the two framing conditions. A falling data line while the clock line is high marks a START. A rising data line while the clock line is high marks a STOP. Both lines are first brought into the local clock domain through a two-flop synchroniser. The block then keeps one sticky flag for the last START seen and one for the last STOP seen. From those two flags it derives a bus-free indication that a master can check before it takes the bus.

A single sticky interrupt flag is raised on every START, every STOP and every byte-complete strobe from an external shift register. It stays raised until an explicit clear pulse arrives. Pulling the enable low forgets the bus state and blocks all new events. The interrupt flag itself is kept through a disable until it is cleared.

Top module: `bus_cond_watch`

## Requirements
- R1: After reset, start_seen and stop_seen are 0, irq is 0 and bus_free is 1.
- R2: A START (sda_in going 1 to 0 while scl_in stays 1) sets start_seen to 1 and clears stop_seen to 0.
- R3: A STOP (sda_in going 0 to 1 while scl_in stays 1) sets stop_seen to 1 and clears start_seen to 0.
- R4: Changes on sda_in while scl_in is 0 change neither flag and do not raise irq.
- R5: bus_free is 1 when stop_seen is 1 or when both flags are 0. It is therefore 0 exactly while start_seen is 1.
- R6: While enable is 0, both flags are 0 from the next clock edge on. Bus conditions and byte_done strobes have no effect on the flags or on irq.
- R7: irq goes to 1 on a START, on a STOP and on a clock edge with byte_done at 1. It then stays 1 until a clock edge with irq_clr at 1.
- R8: When an event that sets irq and irq_clr fall on the same clock edge, irq ends up 1.
- R9: A line change shows on the flags and on irq at the third rising clock edge after it: two synchroniser stages and one status register.
- R10: start_seen and stop_seen are never 1 at the same time.
- R11: While the bus is busy after a START, with no byte_done strobe, the next irq comes from the STOP that ends the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Bus clock line level, asynchronous |
| sda_in | input | 1 | Bus data line level, asynchronous |
| enable | input | 1 | Block enable; 0 clears the flags and blocks events |
| byte_done | input | 1 | One-cycle strobe from the shifter when a byte has been moved |
| irq_clr | input | 1 | One-cycle request to clear irq |
| start_seen | output | 1 | Sticky: the last condition seen was a START |
| stop_seen | output | 1 | Sticky: the last condition seen was a STOP |
| bus_free | output | 1 | Bus may be taken |
| irq | output | 1 | Sticky interrupt flag |

## Verification
Setting irq and clearing it can land on the same clock edge. That is the one case where two functions of the block compete for the same register. The bench provokes it by driving byte_done and irq_clr together for a single cycle. It judges the outcome after that edge: irq must read 1, and a later clear on its own must then drop it. A STOP that arrives while the block is disabled is a second overlap, between two of the flag controls. It is judged by checking that both flags stay 0, bus_free stays 1 and no irq appears.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned RST_STAGES  = 2;

  typedef struct packed {
    logic start;
    logic stop;
  } bus_cond_t;
endpackage

// File: rtl/bcw_sync.sv
module bcw_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= RST_VAL;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bcw_cond_detect.sv
module bcw_cond_detect
  import bcw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl,
  input  logic      sda,
  output bus_cond_t cond
);
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl;
      sda_prev <= sda;
    end
  end

  always_comb begin
    cond.start = scl && scl_prev &&  sda_prev && !sda;
    cond.stop  = scl && scl_prev && !sda_prev &&  sda;
  end

  // R4: no condition can be reported while the clock line is low
  a_r4_no_cond_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !scl |-> !(cond.start || cond.stop));
endmodule

// File: rtl/bcw_status.sv
module bcw_status
  import bcw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  bus_cond_t cond,
  input  logic      byte_done,
  input  logic      irq_clr,
  output logic      start_seen,
  output logic      stop_seen,
  output logic      irq
);
  logic flag_we, start_nx, stop_nx;
  logic irq_set, irq_we, irq_nx;

  always_comb begin
    flag_we  = !enable || cond.start || cond.stop;
    start_nx = enable && cond.start;
    stop_nx  = enable && cond.stop;
  end

  always_comb begin
    irq_set = enable && (cond.start || cond.stop || byte_done);
    irq_we  = irq_set || irq_clr;
    irq_nx  = irq_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else if (flag_we) begin
      start_seen <= start_nx;
      stop_seen  <= stop_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq <= 1'b0;
    else if (irq_we) irq <= irq_nx;
  end

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));
  a_r2_start_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cond.start) |=> (start_seen && !stop_seen));
  a_r3_stop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cond.stop) |=> (stop_seen && !start_seen));
  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_seen && !stop_seen));
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && enable && byte_done) |=> irq);
endmodule

// File: rtl/bus_cond_watch.sv
module bus_cond_watch
  import bcw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic enable,
  input  logic byte_done,
  input  logic irq_clr,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free,
  output logic irq
);
  logic      rst_int_n;
  logic [1:0] line_sync;
  bus_cond_t cond;

  bcw_sync #(.WIDTH(1), .STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  bcw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_line_sync (
    .clk(clk), .rst_n(rst_int_n), .d({scl_in, sda_in}), .q(line_sync)
  );

  bcw_cond_detect u_detect (
    .clk(clk), .rst_n(rst_int_n),
    .scl(line_sync[1]), .sda(line_sync[0]), .cond(cond)
  );

  bcw_status u_status (
    .clk(clk), .rst_n(rst_int_n), .enable(enable), .cond(cond),
    .byte_done(byte_done), .irq_clr(irq_clr),
    .start_seen(start_seen), .stop_seen(stop_seen), .irq(irq)
  );

  assign bus_free = stop_seen || !(start_seen || stop_seen);

  a_r5_free_unless_started: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_free != start_seen);
endmodule

// File: tb/sim_bus_cond_watch.sv
module sim_bus_cond_watch;
  logic clk = 1'b0;
  logic rst_n, scl_in, sda_in, enable, byte_done, irq_clr;
  logic start_seen, stop_seen, bus_free, irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_cond_watch u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .enable(enable), .byte_done(byte_done), .irq_clr(irq_clr),
    .start_seen(start_seen), .stop_seen(stop_seen),
    .bus_free(bus_free), .irq(irq)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "start_seen", start_seen, 1'b0);
    chk("R1", "stop_seen", stop_seen, 1'b0);
    chk("R1", "irq", irq, 1'b0);
    chk("R1", "bus_free", bus_free, 1'b1);
  endtask

  task automatic t_start();
    sda_in = 1'b0;
    cyc(2);
    chk("R9", "start_seen before third edge", start_seen, 1'b0);
    cyc(1);
    chk("R2", "start_seen", start_seen, 1'b1);
    chk("R2", "stop_seen", stop_seen, 1'b0);
    chk("R5", "bus_free busy", bus_free, 1'b0);
    chk("R7", "irq on start", irq, 1'b1);
    cyc(5);
    chk("R7", "irq sticky", irq, 1'b1);
    clear_irq();
    chk("R7", "irq cleared", irq, 1'b0);
  endtask

  task automatic t_data_bits();
    scl_in = 1'b0; cyc(2);
    sda_in = 1'b1; cyc(2);
    scl_in = 1'b1; cyc(2);
    scl_in = 1'b0; cyc(2);
    sda_in = 1'b0; cyc(2);
    scl_in = 1'b1; cyc(2);
    scl_in = 1'b0; cyc(3);
    chk("R4", "irq after data bits", irq, 1'b0);
    chk("R4", "start_seen kept", start_seen, 1'b1);
    chk("R11", "no irq while busy", irq, 1'b0);
  endtask

  task automatic t_byte_done();
    byte_done = 1'b1; cyc(1); byte_done = 1'b0;
    chk("R7", "irq on byte_done", irq, 1'b1);
    clear_irq();
  endtask

  task automatic t_same_cycle();
    byte_done = 1'b1; irq_clr = 1'b1; cyc(1);
    byte_done = 1'b0; irq_clr = 1'b0;
    chk("R8", "set wins over clear", irq, 1'b1);
    clear_irq();
    chk("R8", "later clear", irq, 1'b0);
  endtask

  task automatic t_stop();
    scl_in = 1'b1; cyc(3);
    chk("R11", "no irq on scl rise", irq, 1'b0);
    sda_in = 1'b1; cyc(3);
    chk("R3", "stop_seen", stop_seen, 1'b1);
    chk("R3", "start_seen", start_seen, 1'b0);
    chk("R5", "bus_free after stop", bus_free, 1'b1);
    chk("R11", "irq from stop", irq, 1'b1);
    clear_irq();
  endtask

  task automatic t_disable();
    sda_in = 1'b0; cyc(3);
    chk("R2", "start again", start_seen, 1'b1);
    clear_irq();
    enable = 1'b0; cyc(1);
    chk("R6", "start_seen cleared", start_seen, 1'b0);
    chk("R6", "stop_seen clear", stop_seen, 1'b0);
    chk("R5", "bus_free both clear", bus_free, 1'b1);
    sda_in = 1'b1; cyc(3);
    byte_done = 1'b1; cyc(1); byte_done = 1'b0;
    chk("R6", "stop ignored", stop_seen, 1'b0);
    chk("R6", "no irq while disabled", irq, 1'b0);
    enable = 1'b1; cyc(3);
    chk("R6", "re-enable quiet irq", irq, 1'b0);
    chk("R6", "re-enable flags", start_seen | stop_seen, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
    enable = 1'b1; byte_done = 1'b0; irq_clr = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_start();
    t_data_bits();
    t_byte_done();
    t_same_cycle();
    t_stop();
    t_disable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule